// File: doc/BRIEF.md
# Stepped Volume Ramp Sequencer

This block moves the attenuation of two audio channels, left and right, toward software-chosen targets. It never jumps straight to a target. Each channel's setting is an index into a non-uniform attenuation grid. Large moves are broken into beats that pass through a fixed set of coarse waypoints, which limits the switching noise in the analog attenuator that follows. Each channel has its own target, so balance can be set by giving the two channels different targets.

On each beat the block presents the new index for both channels with a valid flag. It holds that index until the downstream writer acknowledges that it has been applied. The block powers up with both channels at the mute index, so the output stays silent until a first setting has been ramped in. Building the serial control frame and the analog attenuator itself are done elsewhere.

Top module: `vol_ramp_seq`

## Requirements
- R1: After reset both current indices equal the mute index 24, `valid_o` is 0 and `busy_o` is 0.
- R2: The grid has 25 indices. Index 0 is 0 dB, indices 1..10 step 2 dB, 11..14 step 3 dB, 15..19 step 4 dB, 20..23 step 4.5 dB down to -70 dB, and index 24 is mute. A target above 24 is treated as 24.
- R3: When a channel's target is above its current index, its next index is the smallest waypoint (0, 5, 10, 16, 23, 24, that is 0, -10, -20, -40, -70 dB and mute) that lies above the current index. If the target is closer, the next index is the target.
- R4: When a channel's target is below its current index, its next index is the largest waypoint below the current index, or the target if that is closer. From mute the first step is therefore index 23.
- R5: Both channels step on the same beat. A channel that has already reached its target keeps its index while the other channel continues.
- R6: A new index appears with `valid_o` high one cycle after the beat is issued. The index and `valid_o` hold until `ack_i` is sampled high. `valid_o` drops on that edge, and the next beat is issued on the following edge.
- R7: `ack_i` sampled while `valid_o` is low has no effect on the indices or flags.
- R8: `busy_o` is high from the edge that captures a start with a differing target until the last beat is acknowledged and both channels sit at their targets.
- R9: A `start_i` pulse during a ramp replaces the targets. The ramp continues from the current indices toward the new targets.
- R10: A `start_i` pulse whose targets equal the current indices issues no beat and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture both targets this cycle |
| tgt_left_i | input | 5 | Left channel target index |
| tgt_right_i | input | 5 | Right channel target index |
| ack_i | input | 1 | Current beat has been applied downstream |
| cur_left_o | output | 5 | Left channel index to apply |
| cur_right_o | output | 5 | Right channel index to apply |
| valid_o | output | 1 | Indices hold a beat awaiting acknowledge |
| busy_o | output | 1 | A ramp is in progress |

## Verification
A start pulse is registered on one edge. That edge raises `busy_o`, and the first beat's indices and `valid_o` follow on the next edge. An acknowledge lowers `valid_o` on its own edge, and the next beat shows one edge later, so the rising edges of `valid_o` in a ramp are two cycles apart. The bench drives inputs and samples outputs on the falling clock edge. It compares every beat against a queue of expected index pairs at the first falling edge where `valid_o` is seen high. It checks the busy timing at the falling edge just after the start edge, and the spacing between beats whenever acknowledges are automatic. With acknowledges withheld, it checks that a beat's index stays put and that a mid-ramp retarget applies only to the beat after the acknowledge.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LEFT = 0;
  localparam int unsigned CH_RIGHT = 1;
endpackage

// File: rtl/vr_step_calc.sv
module vr_step_calc #(
  parameter int unsigned IW = 5,
  parameter int unsigned NWP = 6,
  parameter logic [NWP-1:0][IW-1:0] WAYPTS = '0
) (
  input  logic [IW-1:0] cur_i,
  input  logic [IW-1:0] tgt_i,
  output logic [IW-1:0] nxt_o
);
  always_comb begin
    logic [IW-1:0] nxt;
    nxt = tgt_i;
    for (int i = 0; i < NWP; i++) begin
      if (tgt_i > cur_i) begin
        if (WAYPTS[i] > cur_i && WAYPTS[i] < nxt) nxt = WAYPTS[i];
      end else if (tgt_i < cur_i) begin
        if (WAYPTS[i] < cur_i && WAYPTS[i] > nxt) nxt = WAYPTS[i];
      end
    end
    nxt_o = nxt;
  end
endmodule

// File: rtl/vr_chan.sv
module vr_chan #(
  parameter int unsigned IW = 5,
  parameter int unsigned NWP = 6,
  parameter logic [NWP-1:0][IW-1:0] WAYPTS = '0,
  parameter logic [IW-1:0] MUTE_IDX = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [IW-1:0] tgt_i,
  input  logic          issue_i,
  output logic [IW-1:0] cur_o,
  output logic          pend_o
);
  logic [IW-1:0] cur_q, tgt_q, nxt, tgt_clamped;

  assign tgt_clamped = (tgt_i > MUTE_IDX) ? MUTE_IDX : tgt_i;

  vr_step_calc #(.IW(IW), .NWP(NWP), .WAYPTS(WAYPTS)) i_step (
    .cur_i(cur_q),
    .tgt_i(tgt_q),
    .nxt_o(nxt)
  );

  // power-up state is mute on both current and target
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= MUTE_IDX;
      tgt_q <= MUTE_IDX;
    end else begin
      if (load_i) tgt_q <= tgt_clamped;
      if (issue_i) cur_q <= nxt;
    end
  end

  assign cur_o  = cur_q;
  assign pend_o = (cur_q != tgt_q);

  a_r3_atten_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && tgt_q > cur_q) |=> (cur_q > $past(cur_q) && cur_q <= $past(tgt_q)));

  a_r4_release_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && tgt_q < cur_q) |=> (cur_q < $past(cur_q) && cur_q >= $past(tgt_q)));

  a_r6_cur_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> cur_q == $past(cur_q));

  a_r2_tgt_in_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tgt_q <= MUTE_IDX);
endmodule

// File: rtl/vr_beat_ctrl.sv
module vr_beat_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic ack_i,
  output logic issue_o,
  output logic valid_o,
  output logic busy_o
);
  logic valid_q;

  assign issue_o = !valid_q && pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               valid_q <= 1'b0;
    else if (issue_o)          valid_q <= 1'b1;
    else if (valid_q && ack_i) valid_q <= 1'b0;
  end

  assign valid_o = valid_q;
  assign busy_o  = valid_q || pend_i;

  a_r6_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_i) |=> valid_q);

  a_r6_drop_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ack_i) |=> !valid_q);

  a_r6_beat_follows_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> valid_q);
endmodule

// File: rtl/vol_ramp_seq.sv
module vol_ramp_seq #(
  parameter int unsigned NLEVELS = 25,
  parameter int unsigned IW = 5,
  parameter int unsigned NWP = 6,
  parameter logic [NWP-1:0][IW-1:0] WAYPTS = {5'd24, 5'd23, 5'd16, 5'd10, 5'd5, 5'd0}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] tgt_left_i,
  input  logic [IW-1:0] tgt_right_i,
  input  logic          ack_i,
  output logic [IW-1:0] cur_left_o,
  output logic [IW-1:0] cur_right_o,
  output logic          valid_o,
  output logic          busy_o
);
  import vol_ramp_pkg::*;

  localparam logic [IW-1:0] MUTE_IDX = IW'(NLEVELS - 1);

  logic [NUM_CH-1:0][IW-1:0] tgt_in, cur;
  logic [NUM_CH-1:0]         pend;
  logic                      issue;

  assign tgt_in[CH_LEFT]  = tgt_left_i;
  assign tgt_in[CH_RIGHT] = tgt_right_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vr_chan #(.IW(IW), .NWP(NWP), .WAYPTS(WAYPTS), .MUTE_IDX(MUTE_IDX)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_i),
      .tgt_i  (tgt_in[c]),
      .issue_i(issue),
      .cur_o  (cur[c]),
      .pend_o (pend[c])
    );
  end

  vr_beat_ctrl i_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (|pend),
    .ack_i  (ack_i),
    .issue_o(issue),
    .valid_o(valid_o),
    .busy_o (busy_o)
  );

  assign cur_left_o  = cur[CH_LEFT];
  assign cur_right_o = cur[CH_RIGHT];

  a_r8_idle_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(cur_left_o) && $stable(cur_right_o)));
endmodule

// File: tb/test_vol_ramp_seq.sv
module test_vol_ramp_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] tgt_l = '0, tgt_r = '0;
  logic       ack_auto = 1'b0, ack_man = 1'b0, auto_en = 1'b1;
  logic       ack;
  logic [4:0] cur_l, cur_r;
  logic       valid, busy;

  int errors = 0, checks = 0, cyc = 0, last_rise = 0;
  bit prev_v = 0, seq_cont = 0, done = 0;
  logic [9:0] exp_q[$];

  assign ack = ack_auto | ack_man;
  always #2 clk = ~clk;

  vol_ramp_seq i_vol_ramp_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .tgt_left_i(tgt_l), .tgt_right_i(tgt_r), .ack_i(ack),
    .cur_left_o(cur_l), .cur_right_o(cur_r), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int l, int r);
    exp_q.push_back({5'(l), 5'(r)});
  endtask

  task automatic do_start(int l, int r);
    tgt_l = 5'(l); tgt_r = 5'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while ((busy || valid) && n < 500) begin @(negedge clk); n++; end
    chk({req, " ramp settles"}, int'(busy), 0);
    chk({req, " all beats seen"}, exp_q.size(), 0);
  endtask

  // acker and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (auto_en && valid && !ack_auto) ack_auto <= 1'b1;
    else ack_auto <= 1'b0;
    if (rst_n && valid && !prev_v) begin
      if (seq_cont) chk("R6 beat spacing", cyc - last_rise, 2);
      last_rise = cyc;
      seq_cont = auto_en;
      if (exp_q.size() == 0) chk("R10 unexpected beat", 1, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R3/R4/R5 left index", int'(cur_l), int'(e[9:5]));
        chk("R3/R4/R5 right index", int'(cur_r), int'(e[4:0]));
      end
    end
    if (!busy || !auto_en) seq_cont = 0;
    prev_v = valid;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 left mute", int'(cur_l), 24);
    chk("R1 right mute", int'(cur_r), 24);
    chk("R1 valid low", int'(valid), 0);
    chk("R1 busy low", int'(busy), 0);

    // R4: mute to 0 dB through waypoints; R8 busy timing
    push(23, 23); push(16, 16); push(10, 10); push(5, 5); push(0, 0);
    do_start(0, 0);
    chk("R8 busy after start", int'(busy), 1);
    chk("R6 valid not yet", int'(valid), 0);
    wait_idle("R4");
    chk("R4 left at 0", int'(cur_l), 0);

    // R3/R5 balance: different targets
    push(5, 5); push(7, 10); push(7, 12);
    do_start(7, 12);
    wait_idle("R5");

    // R3 small step direct to target
    push(8, 12);
    do_start(8, 12);
    wait_idle("R3");

    // R3 left down to mute, R4 right up
    push(10, 10); push(16, 5); push(23, 3); push(24, 3);
    do_start(24, 3);
    wait_idle("R3/R4");

    // R2 out-of-range target clamps to mute
    push(24, 2);
    do_start(31, 2);
    wait_idle("R2");
    chk("R2 left held at mute", int'(cur_l), 24);

    // R9/R6: retarget while beat awaits ack
    auto_en = 1'b0;
    push(23, 2);
    do_start(0, 2);
    while (!valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 valid held", int'(valid), 1);
    chk("R6 index held", int'(cur_l), 23);
    push(20, 2);
    do_start(20, 2);
    chk("R9 index unchanged by retarget", int'(cur_l), 23);
    auto_en = 1'b1;
    wait_idle("R9");
    chk("R9 final left", int'(cur_l), 20);

    // R7: stray ack while idle
    ack_man = 1'b1;
    repeat (3) @(negedge clk);
    ack_man = 1'b0;
    chk("R7 left kept", int'(cur_l), 20);
    chk("R7 right kept", int'(cur_r), 2);
    chk("R7 valid low", int'(valid), 0);

    // R10: same targets, no beat
    do_start(20, 2);
    chk("R10 busy low", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R10 valid low", int'(valid), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule